// File: doc/BRIEF.md
# USB IN Endpoint Transmit Controller

This block holds outgoing data for four USB device endpoints and answers host IN tokens for them. Firmware works through a small byte-wide register file. It loads each endpoint's buffer one byte at a time through a data port. It then arms the endpoint by writing a control byte that holds a byte count, a ready flag and a data-toggle bit. Endpoint 0 has a dedicated control address and a dedicated data port. A shared control address and a shared data port reach whichever endpoint the select register names.

On the packet side, a token decoder upstream presents single-cycle IN and ACK strobes together with an endpoint number. If the addressed endpoint is not armed, the block pulses a NAK request. If it is armed, it streams a data packet to the serializer over a valid/ready byte handshake. The packet is a DATA0 or DATA1 PID byte followed by the counted buffer bytes, and the final byte is marked. The ready flag stays set until the host acknowledges the packet. An unacknowledged packet is therefore sent again unchanged on the next IN token.

The buffers are 8, 8, 6 and 2 bytes deep. CRC, NRZI, bit stuffing and token decoding are left to neighbouring blocks.

Top module: `usb_in_tx_ctrl`

## Requirements
- R1: After reset every control register reads 0, the select register reads 0, tx_valid_o and nak_o are 0, and every buffer pointer is 0.
- R2: Register addresses are: 0 = endpoint 0 control, 1 = control of the selected endpoint, 2 = endpoint 0 data port, 3 = data port of the selected endpoint, 4 = endpoint select (bits 1:0). A control byte carries the count in bits 3:0, the ready flag in bit 4 and the toggle in bit 5. Bits 7:6 read as 0, and a control write reaches only its target endpoint.
- R3: Each endpoint has a byte pointer. Every read or write of its data port accesses the byte at the pointer and then advances the pointer. The pointer wraps at the buffer depth (8, 8, 6, 2 for endpoints 0 to 3). It returns to 0 when the select register is written with that endpoint's number, and when a packet for that endpoint starts.
- R4: An IN token for an endpoint whose ready flag is 0 makes nak_o high for exactly the cycle after the token. No data is sent.
- R5: An IN token for a ready endpoint starts a packet, whose PID byte is valid in the cycle after the token. The PID is 8'hC3 when the toggle is 0 and 8'h4B when it is 1. Buffer bytes from index 0 upward follow the PID.
- R6: The number of data bytes equals the count clamped to the buffer depth. A count of 0 gives a packet made only of the PID byte.
- R7: tx_last_o is high on the final byte of a packet only. While tx_valid_o is high and tx_ready_i is low, the byte and its last flag hold steady.
- R8: An ACK whose endpoint equals that of the last completed packet clears that endpoint's ready flag. It leaves the toggle and the count as they were.
- R9: Without a matching ACK the ready flag stays set. An ACK for another endpoint, or a new IN token arriving first, does not clear it. The next IN token resends the same PID and data.
- R10: IN tokens that arrive while a packet is being sent are ignored: no NAK, and the packet in flight is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (advances a data-port pointer) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| tok_in_i | input | 1 | IN token strobe |
| tok_ack_i | input | 1 | ACK handshake strobe |
| tok_ep_i | input | 2 | Endpoint number for the token or ACK |
| nak_o | output | 1 | Request to send a NAK handshake |
| tx_valid_o | output | 1 | Packet byte valid |
| tx_data_o | output | 8 | Packet byte |
| tx_last_o | output | 1 | Final byte of the packet |
| tx_ready_i | input | 1 | Serializer accepts the byte |

## Verification
Packets are drawn under several conditions: a full 8-byte buffer with DATA1 under a stalling serializer, a 3-byte DATA0 packet, an over-large count on the 2-byte endpoint, and a zero-length packet. Together these tell apart PID selection, clamping, last-flag placement and hold-under-stall. Pointer wrap is tried on the 2-byte and 6-byte buffers, where the two unusual depths would expose an off-by-one. Ready-flag handling is checked three ways: a matching ACK, an ACK for the wrong endpoint, and a retried token. These separate a correct clear from a premature or missing one. A token injected during a stalled packet shows whether busy tokens leak into NAKs or restarts.

// File: rtl/usb_in_tx_pkg.sv
package usb_in_tx_pkg;
  localparam int CNT_W = 4;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;

  localparam logic [2:0] ADDR_CTRL0 = 3'd0;
  localparam logic [2:0] ADDR_CTRLX = 3'd1;
  localparam logic [2:0] ADDR_DATA0 = 3'd2;
  localparam logic [2:0] ADDR_DATAX = 3'd3;
  localparam logic [2:0] ADDR_SEL   = 3'd4;

  typedef struct packed {
    logic             toggle;
    logic             ready;
    logic [CNT_W-1:0] count;
  } ep_ctrl_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PID  = 2'd1,
    TX_DATA = 2'd2
  } tx_state_e;
endpackage

// File: rtl/usb_in_ep_slot.sv
module usb_in_ep_slot
  import usb_in_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  ep_ctrl_t         ctrl_wdata_i,
  input  logic             rdy_clr_i,
  input  logic             port_wr_i,
  input  logic             port_rd_i,
  input  logic [7:0]       port_wdata_i,
  input  logic             ptr_clr_i,
  input  logic [PTR_W-1:0] tx_idx_i,
  output ep_ctrl_t         ctrl_o,
  output logic [7:0]       port_rdata_o,
  output logic [7:0]       tx_rdata_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ep_ctrl_t         ctrl_q;
  logic [IDX_W-1:0] ptr_q;
  logic [7:0]       mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q <= ctrl_wdata_i;
    end else if (rdy_clr_i) begin
      ctrl_q.ready <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_clr_i) begin
      ptr_q <= '0;
    end else if (port_wr_i || port_rd_i) begin
      ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // buffer contents are not reset
  always_ff @(posedge clk_i) begin
    if (port_wr_i && !ptr_clr_i) mem_q[ptr_q] <= port_wdata_i;
  end

  always_comb begin
    tx_rdata_o = 8'h00;
    if (int'(tx_idx_i) < DEPTH) tx_rdata_o = mem_q[tx_idx_i[IDX_W-1:0]];
  end

  assign port_rdata_o = mem_q[ptr_q];
  assign ctrl_o       = ctrl_q;

  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < DEPTH); // R3
  AST_READY_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.ready) |-> ($past(ctrl_we_i) || $past(rdy_clr_i))); // R8
  AST_PTR_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_clr_i |=> ptr_q == '0); // R3
endmodule

// File: rtl/usb_in_tx_packer.sv
module usb_in_tx_packer
  import usb_in_tx_pkg::*;
#(
  parameter int          NUM_EP = 4,
  parameter int          EP_W   = 2,
  parameter int          PTR_W  = 3,
  parameter int unsigned EP_DEPTH [NUM_EP] = '{8, 8, 6, 2}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_in_i,
  input  logic              tok_ack_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic [NUM_EP-1:0] ep_ready_i,
  input  logic [NUM_EP-1:0] ep_toggle_i,
  input  logic [CNT_W-1:0]  ep_count_i [NUM_EP],
  input  logic [7:0]        tx_byte_i,
  input  logic              tx_ready_i,
  output logic [EP_W-1:0]   cur_ep_o,
  output logic [PTR_W-1:0]  tx_idx_o,
  output logic [NUM_EP-1:0] start_o,
  output logic [NUM_EP-1:0] rdy_clr_o,
  output logic              nak_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o
);
  tx_state_e        state_q;
  logic [EP_W-1:0]  ep_q, pend_ep_q;
  logic [CNT_W-1:0] len_q, idx_q, depth_sel, len_sel;
  logic [7:0]       pid_q;
  logic             nak_q, pend_q;
  logic             accept, hit_ready, ack_hit, last_byte, fire;

  always_comb begin
    depth_sel = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (tok_ep_i == EP_W'(i)) depth_sel = CNT_W'(EP_DEPTH[i]);
    end
    len_sel = (ep_count_i[tok_ep_i] > depth_sel) ? depth_sel : ep_count_i[tok_ep_i];
  end

  assign accept    = tok_in_i && (state_q == TX_IDLE);
  assign hit_ready = ep_ready_i[tok_ep_i];
  assign ack_hit   = tok_ack_i && pend_q && (tok_ep_i == pend_ep_q);
  assign fire      = tx_valid_o && tx_ready_i;
  assign last_byte = (state_q == TX_PID) ? (len_q == '0) : (idx_q == len_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TX_IDLE;
      ep_q      <= '0;
      pend_ep_q <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      pid_q     <= PID_DATA0;
      nak_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      nak_q <= 1'b0;
      if (ack_hit) pend_q <= 1'b0;
      unique case (state_q)
        TX_IDLE: begin
          if (accept) begin
            pend_q <= 1'b0;
            if (hit_ready) begin
              state_q <= TX_PID;
              ep_q    <= tok_ep_i;
              len_q   <= len_sel;
              idx_q   <= '0;
              pid_q   <= ep_toggle_i[tok_ep_i] ? PID_DATA1 : PID_DATA0;
            end else begin
              nak_q <= 1'b1;
            end
          end
        end
        TX_PID, TX_DATA: begin
          if (fire) begin
            if (last_byte) begin
              state_q   <= TX_IDLE;
              pend_q    <= 1'b1;
              pend_ep_q <= ep_q;
            end else if (state_q == TX_PID) begin
              state_q <= TX_DATA;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    start_o   = '0;
    rdy_clr_o = '0;
    if (accept && hit_ready) start_o[tok_ep_i] = 1'b1;
    if (ack_hit) rdy_clr_o[pend_ep_q] = 1'b1;
  end

  assign cur_ep_o   = ep_q;
  assign tx_idx_o   = idx_q[PTR_W-1:0];
  assign nak_o      = nak_q;
  assign tx_valid_o = (state_q != TX_IDLE);
  assign tx_data_o  = (state_q == TX_PID) ? pid_q : tx_byte_i;
  assign tx_last_o  = tx_valid_o && last_byte;

  AST_NAK_NOT_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_o |-> !tx_valid_o); // R4
  AST_NAK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_o |-> ($past(tok_in_i) && !$past(tx_valid_o))); // R10
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o))); // R7
  AST_ONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rdy_clr_o)); // R8
  AST_START_PID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |=> (tx_valid_o && !$past(tx_valid_o))); // R5
endmodule

// File: rtl/usb_in_tx_ctrl.sv
module usb_in_tx_ctrl
  import usb_in_tx_pkg::*;
#(
  parameter int          NUM_EP    = 4,
  parameter int          MAX_DEPTH = 8,
  parameter int unsigned EP_DEPTH [NUM_EP] = '{8, 8, 6, 2},
  parameter int          EP_W      = $clog2(NUM_EP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      reg_addr_i,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  input  logic            tok_in_i,
  input  logic            tok_ack_i,
  input  logic [EP_W-1:0] tok_ep_i,
  output logic            nak_o,
  output logic            tx_valid_o,
  output logic [7:0]      tx_data_o,
  output logic            tx_last_o,
  input  logic            tx_ready_i
);
  localparam int PTR_W = $clog2(MAX_DEPTH);

  logic [EP_W-1:0]   sel_q, cur_ep;
  logic [PTR_W-1:0]  tx_idx;
  logic [NUM_EP-1:0] start, rdy_clr, ep_ready, ep_toggle;
  logic [CNT_W-1:0]  ep_count [NUM_EP];
  ep_ctrl_t          ep_ctrl [NUM_EP];
  logic [7:0]        port_rdata [NUM_EP];
  logic [7:0]        tx_rdata [NUM_EP];
  logic              sel_we;
  logic              unused_wdata;

  assign sel_we       = reg_we_i && (reg_addr_i == ADDR_SEL);
  assign unused_wdata = ^reg_wdata_i[7:6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_we) sel_q <= reg_wdata_i[EP_W-1:0];
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic is_sel, hit_ctrl, hit_data, sel_clr;
    assign is_sel   = (sel_q == EP_W'(g));
    assign hit_ctrl = ((reg_addr_i == ADDR_CTRL0) && (g == 0)) || ((reg_addr_i == ADDR_CTRLX) && is_sel);
    assign hit_data = ((reg_addr_i == ADDR_DATA0) && (g == 0)) || ((reg_addr_i == ADDR_DATAX) && is_sel);
    assign sel_clr  = sel_we && (reg_wdata_i[EP_W-1:0] == EP_W'(g));

    usb_in_ep_slot #(
      .DEPTH (int'(EP_DEPTH[g])),
      .PTR_W (PTR_W)
    ) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctrl_we_i    (reg_we_i && hit_ctrl),
      .ctrl_wdata_i (ep_ctrl_t'(reg_wdata_i[5:0])),
      .rdy_clr_i    (rdy_clr[g]),
      .port_wr_i    (reg_we_i && hit_data),
      .port_rd_i    (reg_re_i && hit_data),
      .port_wdata_i (reg_wdata_i),
      .ptr_clr_i    (sel_clr || start[g]),
      .tx_idx_i     (tx_idx),
      .ctrl_o       (ep_ctrl[g]),
      .port_rdata_o (port_rdata[g]),
      .tx_rdata_o   (tx_rdata[g])
    );

    assign ep_ready[g]  = ep_ctrl[g].ready;
    assign ep_toggle[g] = ep_ctrl[g].toggle;
    assign ep_count[g]  = ep_ctrl[g].count;
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL0: reg_rdata_o = {2'b00, ep_ctrl[0]};
      ADDR_CTRLX: reg_rdata_o = {2'b00, ep_ctrl[sel_q]};
      ADDR_DATA0: reg_rdata_o = port_rdata[0];
      ADDR_DATAX: reg_rdata_o = port_rdata[sel_q];
      ADDR_SEL:   reg_rdata_o = 8'(sel_q);
      default:    reg_rdata_o = 8'h00;
    endcase
  end

  usb_in_tx_packer #(
    .NUM_EP   (NUM_EP),
    .EP_W     (EP_W),
    .PTR_W    (PTR_W),
    .EP_DEPTH (EP_DEPTH)
  ) u_packer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tok_in_i    (tok_in_i),
    .tok_ack_i   (tok_ack_i),
    .tok_ep_i    (tok_ep_i),
    .ep_ready_i  (ep_ready),
    .ep_toggle_i (ep_toggle),
    .ep_count_i  (ep_count),
    .tx_byte_i   (tx_rdata[cur_ep]),
    .tx_ready_i  (tx_ready_i),
    .cur_ep_o    (cur_ep),
    .tx_idx_o    (tx_idx),
    .start_o     (start),
    .rdy_clr_o   (rdy_clr),
    .nak_o       (nak_o),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_last_o   (tx_last_o)
  );

  AST_CLEAR_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_clr != '0) |-> (tok_ack_i && !tx_valid_o)); // R8
endmodule

// File: tb/usb_in_tx_ctrl_test.sv
module usb_in_tx_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       tok_in = 1'b0, tok_ack = 1'b0;
  logic [1:0] tok_ep = '0;
  logic       nak, tx_valid, tx_last, tx_ready = 1'b0;
  logic [7:0] tx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_in_tx_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tok_in_i(tok_in), .tok_ack_i(tok_ack), .tok_ep_i(tok_ep),
    .nak_o(nak), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic token(input logic [1:0] ep);
    tok_ep = ep; tok_in = 1'b1;
    @(negedge clk);
    tok_in = 1'b0;
  endtask

  task automatic ack(input logic [1:0] ep);
    tok_ep = ep; tok_ack = 1'b1;
    @(negedge clk);
    tok_ack = 1'b0;
  endtask

  // collect a packet; stall_mod > 1 inserts a stall every stall_mod cycles
  task automatic collect(input string req, input logic [7:0] exp [16], input int n, input int stall_mod);
    int got = 0;
    int guard = 0;
    while (got < n && guard < 200) begin
      tx_ready = (stall_mod < 2) || ((guard % stall_mod) != 0);
      if (tx_valid && tx_ready) begin
        chk({req, " byte"}, tx_data, exp[got]);
        chk({req, " last"}, tx_last, (got == n - 1));
        got++;
      end
      @(negedge clk);
      guard++;
    end
    tx_ready = 1'b0;
    chk({req, " count"}, got, n);
    chk({req, " idle after"}, tx_valid, 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_rd(3'd0, d); chk("R1 ctrl0", d, 0);
    reg_rd(3'd1, d); chk("R1 ctrlx", d, 0);
    reg_rd(3'd4, d); chk("R1 sel", d, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 nak", nak, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    reg_wr(3'd4, 8'h02);
    reg_rd(3'd4, d); chk("R2 sel readback", d, 8'h02);
    reg_wr(3'd1, 8'hC7);
    reg_rd(3'd1, d); chk("R2 ctrl upper bits zero", d, 8'h07);
    reg_rd(3'd0, d); chk("R2 ctrl0 untouched", d, 8'h00);
    reg_wr(3'd1, 8'h00);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    reg_wr(3'd4, 8'h03);
    reg_wr(3'd3, 8'h11);
    reg_wr(3'd3, 8'h22);
    reg_rd(3'd3, d); chk("R3 ep3 idx0", d, 8'h11);
    reg_rd(3'd3, d); chk("R3 ep3 idx1", d, 8'h22);
    reg_rd(3'd3, d); chk("R3 ep3 wrap", d, 8'h11);
    reg_wr(3'd4, 8'h03);
    reg_rd(3'd3, d); chk("R3 ep3 reselect", d, 8'h11);
    reg_wr(3'd4, 8'h02);
    for (int i = 0; i < 6; i++) reg_wr(3'd3, 8'h20 + 8'(i));
    reg_wr(3'd3, 8'h99);
    reg_rd(3'd3, d); chk("R3 ep2 after wrap idx1", d, 8'h21);
    reg_wr(3'd4, 8'h02);
    reg_rd(3'd3, d); chk("R3 ep2 wrap overwrote idx0", d, 8'h99);
  endtask

  task automatic t_nak();
    token(2'd2);
    chk("R4 nak pulse", nak, 1);
    chk("R4 no data", tx_valid, 0);
    @(negedge clk);
    chk("R4 nak one cycle", nak, 0);
  endtask

  task automatic t_send_ep1();
    logic [7:0] e [16];
    logic [7:0] d;
    reg_wr(3'd4, 8'h01);
    for (int i = 0; i < 8; i++) reg_wr(3'd3, 8'hA0 + 8'(i));
    reg_wr(3'd1, 8'h38);
    e[0] = 8'h4B;
    for (int i = 0; i < 8; i++) e[i+1] = 8'hA0 + 8'(i);
    token(2'd1);
    chk("R5 valid after token", tx_valid, 1);
    collect("R5 R7 ep1 DATA1", e, 9, 3);
    ack(2'd1);
    reg_rd(3'd1, d); chk("R8 ack clears ready only", d, 8'h28);
  endtask

  task automatic t_retry_ep0();
    logic [7:0] e [16];
    logic [7:0] d;
    reg_wr(3'd2, 8'h01);
    reg_wr(3'd2, 8'h02);
    reg_wr(3'd2, 8'h03);
    reg_wr(3'd0, 8'h13);
    e[0] = 8'hC3; e[1] = 8'h01; e[2] = 8'h02; e[3] = 8'h03;
    token(2'd0);
    collect("R5 ep0 DATA0", e, 4, 0);
    token(2'd0);
    collect("R9 ep0 resend", e, 4, 0);
    ack(2'd3);
    reg_rd(3'd0, d); chk("R9 wrong-ep ack keeps ready", d, 8'h13);
    ack(2'd0);
    reg_rd(3'd0, d); chk("R8 ep0 ack clears", d, 8'h03);
  endtask

  task automatic t_clamp_zero();
    logic [7:0] e [16];
    logic [7:0] d;
    reg_wr(3'd4, 8'h03);
    reg_wr(3'd1, 8'h1F);
    e[0] = 8'hC3; e[1] = 8'h11; e[2] = 8'h22;
    token(2'd3);
    collect("R6 clamp ep3", e, 3, 2);
    ack(2'd3);
    reg_wr(3'd4, 8'h02);
    reg_wr(3'd1, 8'h30);
    e[0] = 8'h4B;
    token(2'd2);
    collect("R6 zero length", e, 1, 0);
    ack(2'd2);
    reg_rd(3'd1, d); chk("R8 zlp ack clears", d, 8'h20);
  endtask

  task automatic t_busy();
    logic [7:0] e [16];
    reg_wr(3'd4, 8'h01);
    reg_wr(3'd1, 8'h18);
    e[0] = 8'hC3;
    for (int i = 0; i < 8; i++) e[i+1] = 8'hA0 + 8'(i);
    token(2'd1);
    tx_ready = 1'b0;
    token(2'd2);
    chk("R10 no nak while busy", nak, 0);
    chk("R10 packet unchanged", tx_data, 8'hC3);
    chk("R7 held under stall", tx_valid, 1);
    collect("R10 full packet", e, 9, 0);
    ack(2'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_pointer();
    t_nak();
    t_send_ep1();
    t_retry_ep0();
    t_clamp_zero();
    t_busy();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule